// File: doc/BRIEF.md
# Stream-Fed Serial Peripheral Master

This block is a serial peripheral (SPI) master whose words come from and go to two small FIFOs rather than from a processor register. A memory-side streaming engine writes outgoing words into the transmit FIFO through a valid/ready port. It reads incoming words out of the receive FIFO through a second valid/ready port. A single start pulse latches the configuration: word count, SCLK half-period, transmit enable, receive enable and the send-zeros option. The block then runs the whole transfer by itself and raises a one-cycle `done` pulse when it has finished.

The serial side works in mode 0. SCLK idles low, MISO is captured on each rising edge, and MOSI moves on each falling edge, most significant bit first. When the transmit FIFO has no word ready at a word boundary, or the receive FIFO has no room for the word just assembled, the master does not report an error. It stops between words with SCLK low and chip select still asserted, and it continues once the FIFO can serve it. When transmit is disabled, MOSI carries either all zeros or the most recently transmitted word again, as chosen at start.

The controller is a six-state machine. In `ST_IDLE`, a start with a non-zero count goes to `ST_LOAD`. In `ST_LOAD`, the machine waits for a source word and then goes to `ST_LOW`. At the end of its half-period, `ST_LOW` goes to `ST_HIGH`, which is the rising edge. At the end of its half-period, `ST_HIGH` goes back to `ST_LOW` (the falling edge with a shift), or to `ST_PUSH` after the last bit of the word. `ST_PUSH` waits for receive room and steps the word counter down. From there it goes to `ST_LOAD`, or to `ST_TAIL` when the counter steps from 1 to 0. `ST_TAIL` holds chip select for a half-period and then returns to `ST_IDLE`, raising `done`.

Top module: `spi_dma_master`

## Requirements
- R1: With transmit enabled, each word taken from the transmit stream is sent on MOSI most significant bit first, in the order it was accepted, one word per counted word.
- R2: With receive enabled, the WORD_W bits captured from MISO on the rising SCLK edges of each word are assembled MSB first and delivered on the receive stream in arrival order. With receive disabled, nothing is delivered.
- R3: SCLK idles low. Every high phase, and every low phase inside a word, lasts exactly `cfg_half` system clocks, where a `cfg_half` of 0 acts as 1. MOSI never changes while SCLK is high.
- R4: A transfer produces exactly `cfg_words` words (WORD_W rising edges each) and ends with a single one-cycle `done` pulse, during which `cs_n` is already high and `busy` is low. A start with `cfg_words` = 0 is ignored.
- R5: If the transmit FIFO is empty when the next word is due, SCLK stays low and `cs_n` stays low with no error. The transfer resumes when a word arrives.
- R6: If the receive FIFO is full when a word completes, SCLK stays low and `cs_n` stays low with no error. Exactly one word beyond the FIFO depth is shifted before the stall, and the transfer resumes when room is freed.
- R7: With transmit disabled, MOSI sends all-zero words when `cfg_send_zeros` = 1. When it is 0, MOSI repeats the last word the block took from the transmit FIFO.
- R8: `cs_n` goes low exactly `cfg_half` clocks (at least one) before the first rising SCLK edge, and rises no earlier than `cfg_half` clocks after the last falling edge. SCLK is never high while `cs_n` is high.
- R9: Each FIFO holds FIFO_DEPTH (default 4) words. While idle, `tx_s_ready` falls after four accepted words. After reset, `tx_s_ready` = 1 and `rx_m_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (idle only) |
| cfg_words | input | CNT_W | Number of words in the transfer |
| cfg_half | input | DIV_W | SCLK half-period in system clocks (0 treated as 1) |
| cfg_tx_en | input | 1 | Take MOSI words from the transmit FIFO |
| cfg_rx_en | input | 1 | Store received words in the receive FIFO |
| cfg_send_zeros | input | 1 | Transmit disabled: send zeros instead of repeating the last word |
| tx_s_valid | input | 1 | Transmit stream word valid |
| tx_s_ready | output | 1 | Transmit FIFO has room |
| tx_s_data | input | WORD_W | Transmit stream word |
| rx_m_valid | output | 1 | Receive FIFO holds a word |
| rx_m_ready | input | 1 | Receive stream consumer ready |
| rx_m_data | output | WORD_W | Receive stream word |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The main path is tried with mixed bit patterns (0xA5, 0x3C, 0xF0, 0x96) at a three-clock half-period. These separate bit-order and word-order faults. Single-bit and uniform words (0x01, 0x80, 0xFF, 0x00) at the minimum divider expose off-by-one shifting and edge-timing faults. A transmit stream that runs dry mid-transfer, and a receive consumer that holds off until the FIFO fills, show whether the block stalls at a word boundary rather than losing or repeating data. Receive-only runs with and without the zero option separate the two MOSI fill sources, and a zero-count start shows that the machine stays idle.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_LOW  = 3'd2,
        ST_HIGH = 3'd3,
        ST_PUSH = 3'd4,
        ST_TAIL = 3'd5
    } xfer_state_e;

endpackage

// File: rtl/sdm_fifo.sv
module sdm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] fill_q;
    logic          do_wr, do_rd;

    assign in_ready  = (fill_q != CNT_FULL);
    assign out_valid = (fill_q != '0);
    assign out_data  = store[rd_q];
    assign do_wr     = in_valid && in_ready;
    assign do_rd     = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            store[wr_q] <= in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            if (do_wr) begin
                wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
            end
            if (do_rd) begin
                rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end
endmodule

// File: rtl/sdm_phase_timer.sv
module sdm_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] half,
    output logic             expired
);
    logic [DIV_W-1:0] left_q;
    logic [DIV_W-1:0] span;

    // a half-period of 0 behaves as 1 (minimum divider of 2)
    assign span    = (half == '0) ? '0 : half - 1'b1;
    assign expired = (left_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (restart) begin
            left_q <= span;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/sdm_shifter.sv
module sdm_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift_out,
    input  logic         sample_in,
    input  logic         serial_in,
    output logic         serial_out,
    output logic [W-1:0] par_out
);
    logic [W-1:0] out_sh_q;
    logic [W-1:0] in_sh_q;

    assign serial_out = out_sh_q[W-1];
    assign par_out    = in_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sh_q <= '0;
            in_sh_q  <= '0;
        end else begin
            if (load) begin
                out_sh_q <= load_data;
            end else if (shift_out) begin
                out_sh_q <= {out_sh_q[W-2:0], 1'b0};
            end
            if (sample_in) begin
                in_sh_q <= {in_sh_q[W-2:0], serial_in};
            end
        end
    end
endmodule

// File: rtl/spi_dma_master.sv
module spi_dma_master
    import spi_dma_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cfg_words,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              cfg_tx_en,
    input  logic              cfg_rx_en,
    input  logic              cfg_send_zeros,
    input  logic              tx_s_valid,
    output logic              tx_s_ready,
    input  logic [WORD_W-1:0] tx_s_data,
    output logic              rx_m_valid,
    input  logic              rx_m_ready,
    output logic [WORD_W-1:0] rx_m_data,
    output logic              sclk,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              done
);
    localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BW-1:0]    LAST_BIT  = BW'(WORD_W - 1);
    localparam logic [CNT_W-1:0] FINAL_CNT = CNT_W'(1);

    xfer_state_e       state_q, state_nx;
    logic [CNT_W-1:0]  left_q;
    logic [BW-1:0]     bit_q;
    logic [DIV_W-1:0]  half_q;
    logic              tx_en_q, rx_en_q, zeros_q;
    logic [WORD_W-1:0] last_q;
    logic              cs_act_q;
    logic              done_q;

    logic              txf_valid, txf_pop;
    logic [WORD_W-1:0] txf_data;
    logic              rxf_ready, rxf_push;
    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] src_word;
    logic              tmr_restart, tmr_expired;
    logic              sh_load, sh_rise, sh_fall;
    logic              src_ready, sink_ready;
    logic              word_end;
    logic              mosi_w;

    sdm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_s_valid),
        .in_ready  (tx_s_ready),
        .in_data   (tx_s_data),
        .out_valid (txf_valid),
        .out_ready (txf_pop),
        .out_data  (txf_data)
    );

    sdm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rxf_push),
        .in_ready  (rxf_ready),
        .in_data   (rx_word),
        .out_valid (rx_m_valid),
        .out_ready (rx_m_ready),
        .out_data  (rx_m_data)
    );

    sdm_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .half    (half_q),
        .expired (tmr_expired)
    );

    sdm_shifter #(.W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .load_data  (src_word),
        .shift_out  (sh_fall),
        .sample_in  (sh_rise),
        .serial_in  (miso),
        .serial_out (mosi_w),
        .par_out    (rx_word)
    );

    // word source and sink availability
    assign src_ready  = !tx_en_q || txf_valid;
    assign sink_ready = !rx_en_q || rxf_ready;
    assign src_word   = tx_en_q ? txf_data : (zeros_q ? '0 : last_q);

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (start && (cfg_words != '0)) state_nx = ST_LOAD;
            ST_LOAD: if (src_ready) state_nx = ST_LOW;
            ST_LOW:  if (tmr_expired) state_nx = ST_HIGH;
            ST_HIGH: if (tmr_expired) state_nx = (bit_q == LAST_BIT) ? ST_PUSH : ST_LOW;
            ST_PUSH: if (sink_ready) state_nx = (left_q == FINAL_CNT) ? ST_TAIL : ST_LOAD;
            ST_TAIL: if (tmr_expired) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath strobes
    assign tmr_restart = (state_nx != state_q);
    assign sh_load     = (state_q == ST_LOAD) && src_ready;
    assign txf_pop     = (state_q == ST_LOAD) && tx_en_q && txf_valid;
    assign sh_rise     = (state_q == ST_LOW) && tmr_expired;
    assign sh_fall     = (state_q == ST_HIGH) && tmr_expired && (bit_q != LAST_BIT);
    assign rxf_push    = (state_q == ST_PUSH) && rx_en_q && rxf_ready;
    assign word_end    = (state_q == ST_PUSH) && sink_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q   <= '0;
            bit_q    <= '0;
            half_q   <= '0;
            tx_en_q  <= 1'b0;
            rx_en_q  <= 1'b0;
            zeros_q  <= 1'b0;
            last_q   <= '0;
            cs_act_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_TAIL) && tmr_expired;
            if ((state_q == ST_IDLE) && start && (cfg_words != '0)) begin
                left_q  <= cfg_words;
                half_q  <= cfg_half;
                tx_en_q <= cfg_tx_en;
                rx_en_q <= cfg_rx_en;
                zeros_q <= cfg_send_zeros;
            end
            if (sh_load) begin
                bit_q    <= '0;
                cs_act_q <= 1'b1;
            end else if (sh_fall) begin
                bit_q <= bit_q + 1'b1;
            end
            if (txf_pop) begin
                last_q <= txf_data;
            end
            if (word_end) begin
                left_q <= left_q - 1'b1;
            end
            if ((state_q == ST_TAIL) && tmr_expired) begin
                cs_act_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        sclk = (state_q == ST_HIGH);
        cs_n = !cs_act_q;
        mosi = mosi_w;
        busy = (state_q != ST_IDLE);
        done = done_q;
    end
endmodule

// File: rtl/sdm_checker.sv
module sdm_checker (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic done
);
    AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                                   // R8
    AST_SELECT_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $past(!cs_n));                     // R8
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));                           // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                   // R4
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));                         // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !sclk));                        // R8
endmodule

bind spi_dma_master sdm_checker u_sdm_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .mosi  (mosi),
    .busy  (busy),
    .done  (done)
);

// File: tb/test_spi_dma_master.sv
module test_spi_dma_master;
    localparam int W  = 8;
    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] cfg_words = '0;
    logic [DW-1:0] cfg_half = '0;
    logic          cfg_tx_en = 1'b0, cfg_rx_en = 1'b0, cfg_send_zeros = 1'b0;
    logic          tx_s_valid = 1'b0;
    logic          tx_s_ready;
    logic [W-1:0]  tx_s_data = '0;
    logic          rx_m_valid;
    logic          rx_m_ready = 1'b1;
    logic [W-1:0]  rx_m_data;
    logic          sclk, cs_n, mosi, busy, done;
    logic          miso = 1'b0;

    always #10 clk = ~clk;

    spi_dma_master i_spi_dma_master (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_words(cfg_words),
        .cfg_half(cfg_half), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
        .cfg_send_zeros(cfg_send_zeros), .tx_s_valid(tx_s_valid),
        .tx_s_ready(tx_s_ready), .tx_s_data(tx_s_data), .rx_m_valid(rx_m_valid),
        .rx_m_ready(rx_m_ready), .rx_m_data(rx_m_data), .sclk(sclk), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .busy(busy), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference model state: slave device and line observer
    logic [W-1:0] slv_q[$];
    logic [W-1:0] got_mosi[$];
    logic [W-1:0] got_rx[$];
    logic [W-1:0] exp_q[$];
    logic [W-1:0] cur_word = '0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    int   plen = 0, bidx = 0, wsel = 0, rises = 0, done_cnt = 0, exp_half = 1;
    bit   first_bit = 1'b0;
    int   e_phase = 0, e_mosi = 0, e_cs = 0, e_lead = 0, e_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_m_valid && rx_m_ready) got_rx.push_back(rx_m_data);
            if (done) begin
                done_cnt++;
                if (!cs_n || busy) e_done++;
            end
            if (cs_n && sclk) e_cs++;
            if (sclk && prev_sclk && (mosi !== prev_mosi)) e_mosi++;
            if (prev_cs && !cs_n) begin
                first_bit = 1'b1; bidx = 0; wsel = 0; plen = 1;
            end else if (!prev_cs && cs_n) begin
                if (plen < exp_half) e_cs++;
                plen = 1;
            end else if (sclk && !prev_sclk) begin
                if (first_bit) begin
                    if (plen != exp_half) e_lead++;
                    first_bit = 1'b0;
                end else if (bidx != 0) begin
                    if (plen != exp_half) e_phase++;
                end else if (plen < exp_half) begin
                    e_phase++;
                end
                cur_word = {cur_word[W-2:0], mosi};
                bidx++; rises++;
                if (bidx == W) begin
                    got_mosi.push_back(cur_word);
                    bidx = 0; wsel++;
                end
                plen = 1;
            end else if (!sclk && prev_sclk) begin
                if (plen != exp_half) e_phase++;
                plen = 1;
            end else begin
                plen++;
            end
            prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
        end
        miso = (wsel < slv_q.size()) ? slv_q[wsel][W-1-bidx] : 1'b0;
    end

    task automatic push_tx(input logic [W-1:0] w);
        tx_s_valid = 1'b1;
        tx_s_data  = w;
        forever begin
            @(negedge clk);
            if (tx_s_ready) break;
        end
        @(posedge clk); #1;
        tx_s_valid = 1'b0;
    endtask

    task automatic run(input int cnt, input int half, input bit tx,
                       input bit rx, input bit sz);
        exp_half = (half == 0) ? 1 : half;
        got_mosi.delete(); got_rx.delete();
        rises = 0; done_cnt = 0;
        e_phase = 0; e_mosi = 0; e_cs = 0; e_lead = 0; e_done = 0;
        cfg_words = CW'(cnt); cfg_half = DW'(half);
        cfg_tx_en = tx; cfg_rx_en = rx; cfg_send_zeros = sz;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            @(posedge clk); #1;
            if (done_cnt > 0) break;
        end
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic finish_xfer(input string req, input int cnt, input bit rx);
        chk(got_mosi.size() == cnt, "R1", {req, " mosi word count"}, got_mosi.size(), cnt);
        for (int i = 0; i < cnt; i++) begin
            if (i < got_mosi.size())
                chk(got_mosi[i] == exp_q[i], req, "mosi word", got_mosi[i], exp_q[i]);
        end
        if (rx) begin
            chk(got_rx.size() == cnt, "R2", "rx word count", got_rx.size(), cnt);
            for (int i = 0; i < cnt; i++) begin
                if (i < got_rx.size())
                    chk(got_rx[i] == slv_q[i], "R2", "rx word", got_rx[i], slv_q[i]);
            end
        end else begin
            chk(got_rx.size() == 0, "R2", "rx words with receive off", got_rx.size(), 0);
        end
        chk(rises == cnt * W, "R4", "rising edges", rises, cnt * W);
        chk(done_cnt == 1 && e_done == 0, "R4", "done pulses", done_cnt, 1);
        chk(e_phase == 0 && e_mosi == 0, "R3", "phase/mosi violations", e_phase + e_mosi, 0);
        chk(e_lead == 0 && e_cs == 0, "R8", "chip select framing violations", e_lead + e_cs, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R8", "reset lines", {cs_n, sclk}, 2);
        chk(done == 1'b0 && busy == 1'b0, "R4", "reset done/busy", {done, busy}, 0);
        chk(tx_s_ready == 1'b1 && rx_m_valid == 1'b0, "R9", "reset stream flags",
            {tx_s_ready, rx_m_valid}, 2);
        @(posedge clk); #1;

        // T1 R1 R2 R9: full FIFO, mixed patterns, half-period 3
        slv_q = '{8'h5A, 8'hC3, 8'h0F, 8'h69};
        exp_q = '{8'hA5, 8'h3C, 8'hF0, 8'h96};
        foreach (exp_q[i]) push_tx(exp_q[i]);
        @(negedge clk);
        chk(tx_s_ready == 1'b0, "R9", "tx ready after four words", tx_s_ready, 0);
        @(posedge clk); #1;
        run(4, 3, 1'b1, 1'b1, 1'b0);
        wait_done(2000);
        finish_xfer("R1", 4, 1'b1);

        // T2 R3: divider 0 acts as minimum, receive disabled
        slv_q = '{8'hFF, 8'h00, 8'h81, 8'h7E};
        exp_q = '{8'h01, 8'h80, 8'hFF, 8'h00};
        foreach (exp_q[i]) push_tx(exp_q[i]);
        run(4, 0, 1'b1, 1'b0, 1'b0);
        wait_done(2000);
        finish_xfer("R3", 4, 1'b0);

        // T3 R5: transmit stream runs dry mid-transfer
        slv_q = '{8'h12, 8'h34, 8'h56, 8'h78};
        exp_q = '{8'h11, 8'h22, 8'h33, 8'h44};
        push_tx(8'h11); push_tx(8'h22);
        run(4, 2, 1'b1, 1'b1, 1'b0);
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(busy && !cs_n && !sclk, "R5", "stalled lines busy/cs_n/sclk",
            {busy, cs_n, sclk}, 4);
        chk(rises == 2 * W, "R5", "edges before stall", rises, 2 * W);
        chk(done_cnt == 0, "R5", "no done during stall", done_cnt, 0);
        @(posedge clk); #1;
        push_tx(8'h33); push_tx(8'h44);
        wait_done(2000);
        finish_xfer("R5", 4, 1'b1);

        // T4 R6 R7: receive-only zeros with receive consumer holding off
        rx_m_ready = 1'b0;
        slv_q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 8'h42, 8'h24};
        exp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        run(6, 1, 1'b0, 1'b1, 1'b1);
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(rises == 5 * W, "R6", "edges before full stall", rises, 5 * W);
        chk(!cs_n && !sclk && rx_m_valid, "R6", "stalled lines cs_n/sclk/valid",
            {cs_n, sclk, rx_m_valid}, 1);
        chk(got_rx.size() == 0 && done_cnt == 0, "R6", "no output during hold",
            got_rx.size() + done_cnt, 0);
        @(posedge clk); #1;
        rx_m_ready = 1'b1;
        wait_done(2000);
        finish_xfer("R7", 6, 1'b1);

        // T5 R7: receive-only repeating last transmitted word
        slv_q = '{8'h01, 8'h02, 8'h03};
        exp_q = '{8'h44, 8'h44, 8'h44};
        run(3, 2, 1'b0, 1'b1, 1'b0);
        wait_done(2000);
        finish_xfer("R7", 3, 1'b1);

        // T6 R4: zero count start is ignored
        run(0, 1, 1'b1, 1'b1, 1'b0);
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(!busy && cs_n && rises == 0 && done_cnt == 0, "R4", "zero-count start activity",
            rises + done_cnt + int'(busy), 0);

        summary();
        $finish;
    end
endmodule